// File: doc/BRIEF.md
# Virtual Screen Pitch and Pan Address Calculator

This block keeps the geometry of a virtual frame buffer that is larger than the visible screen. Software writes a virtual width, or a horizontal or vertical pan offset, through a small write channel. From these values, the current pixel depth and the size of video memory, the block derives three results: the byte pitch of one virtual line, the number of virtual lines that fit in memory, and the address where scan-out should start. The start address is given in 32-bit word units.

A width write is checked against the visible resolution before it is committed. The line count comes from a serial restoring divider that produces one quotient bit per clock. While that divider runs, the write channel holds off further writes. Every accepted write ends with a one-cycle `done` pulse. A rejected write leaves every output as it was.

The write channel uses valid/ready. The sender raises `wr_valid` and holds `wr_sel` and `wr_data` steady until it samples `wr_ready` high at a rising edge. That edge is the transfer. `wr_ready` stays low from the transfer of a width that passes the first checks until its division has finished. The resolution, depth and memory-size inputs are plain levels. They are sampled when a write is accepted and again when the division result is compared.

Top module: `vscreen_calc`

## Requirements
- R1: After reset, `line_offset`, `virt_width`, `virt_height` and `start_addr` are zero, `wr_ready` is high, and `busy` and `done` are low.
- R2: At a depth of 4 bits per pixel (`cur_bpp` = 4), the pitch of a width W is W shifted right by one.
- R3: At any other depth D, the pitch of a width W is W × floor((D + 7) / 8). For example, D = 15 gives 2 bytes per pixel and D = 32 gives 4.
- R4: A width write (`wr_sel` = 0) with a value below `cur_xres` is rejected. `done` pulses once and no output changes.
- R5: A width whose pitch is zero (for example `cur_bpp` = 0) is rejected without starting the divider. `busy` stays low and no output changes.
- R6: A width that passes the checks sets `virt_height` to floor(`vram_bytes` / pitch). `virt_width`, `virt_height` and `line_offset` change together, in the same cycle as the `done` pulse.
- R7: If floor(`vram_bytes` / pitch) is below `cur_yres`, the width is rejected with no output change. A quotient equal to `cur_yres` is accepted.
- R8: A write of the X offset (`wr_sel` = 1) or the Y offset (`wr_sel` = 2) sets `start_addr` to (`line_offset` × Y + Xbytes) >> 2. Xbytes is the X offset converted to bytes by the rules of R2 and R3. The other offset keeps its last written value. `start_addr` and `done` update on the clock edge that accepts the write.
- R9: A write transfers only on a rising edge where `wr_valid` and `wr_ready` are both high. Each transfer yields exactly one `done` pulse, and `wr_ready` is low whenever `busy` is high.
- R10: For an accepted width, `busy` is high for exactly MW + 1 cycles, where MW is the memory-size width. It then falls in the cycle in which `done` rises.
- R11: A write with `wr_sel` = 3 is taken and answered with `done`, but changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A write is offered |
| wr_ready | output | 1 | The block can take a write |
| wr_sel | input | 2 | 0 width, 1 X offset, 2 Y offset, 3 unused |
| wr_data | input | DW | Value written |
| cur_xres | input | DW | Visible horizontal resolution |
| cur_yres | input | DW | Visible vertical resolution |
| cur_bpp | input | BPPW | Bits per pixel |
| vram_bytes | input | MW | Video memory size in bytes |
| line_offset | output | DW+3 | Bytes per virtual line |
| virt_width | output | DW | Committed virtual width in pixels |
| virt_height | output | MW | Virtual lines that fit in memory |
| start_addr | output | 2*DW+2 | Scan-out start in 32-bit words |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle pulse closing each accepted write |

## Verification
Width writes are tried at depths of 4, 8, 15 and 32 bits per pixel. These four depths separate the halving rule from the multiply rule, and they show whether the bytes-per-pixel value is rounded up. Each of the three rejection paths gets its own width: one narrower than the screen, one at depth zero, and one whose line count falls one short of the vertical resolution. A line count that exactly equals the resolution is also tried, which pins the acceptance comparison to "greater or equal". Pan writes are made in both orders and at depths 4 and 8, so that a stale offset, a wrong byte conversion or a missing divide-by-four each give a different start address.

// File: rtl/vscreen_pkg.sv
package vscreen_pkg;

  typedef enum logic [1:0] {
    SEL_WIDTH = 2'd0,
    SEL_XOFF  = 2'd1,
    SEL_YOFF  = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } calc_state_e;

  // whole bytes a pixel of the given depth occupies, rounded up
  function automatic logic [3:0] bytes_per_px(input logic [5:0] bpp);
    logic [6:0] sum;
    sum = {1'b0, bpp} + 7'd7;
    return sum[6:3];
  endfunction

endpackage

// File: rtl/vscreen_pitch.sv
// Converts a pixel count to a byte count for the current depth.
module vscreen_pitch #(
  parameter int DW   = 16,
  parameter int BPPW = 6,
  parameter int OW   = DW + 3
) (
  input  logic [DW-1:0]   pixels,
  input  logic [BPPW-1:0] bpp,
  output logic [OW-1:0]   bytes
);
  import vscreen_pkg::*;

  logic [3:0]    mult;
  logic [OW-1:0] wide;

  always_comb begin
    mult  = bytes_per_px(6'(bpp));
    wide  = OW'(pixels);
    if (bpp == BPPW'(4)) bytes = wide >> 1;
    else                 bytes = wide * OW'(mult);
  end

endmodule

// File: rtl/vscreen_div.sv
// Serial restoring divider: one quotient bit per clock, NW steps per run.
module vscreen_div #(
  parameter int NW = 24,
  parameter int DVW = 19
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic [NW-1:0]  quotient,
  output logic           fin
);
  localparam int CW = $clog2(NW + 1);

  logic [DVW:0]   rem_q;
  logic [NW-1:0]  quo_q;
  logic [DVW-1:0] dvs_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q;
  logic [DVW:0]   rem_sh;
  logic           take;

  always_comb begin
    rem_sh = {rem_q[DVW-1:0], quo_q[NW-1]};
    take   = rem_sh >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
        quo_q <= {quo_q[NW-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/vscreen_start.sv
// Start address in 32-bit words from pitch, pan offsets and depth.
module vscreen_start #(
  parameter int DW   = 16,
  parameter int BPPW = 6,
  parameter int LOW  = DW + 3,
  parameter int SAW  = LOW + DW - 1
) (
  input  logic [LOW-1:0]  pitch,
  input  logic [DW-1:0]   xoff,
  input  logic [DW-1:0]   yoff,
  input  logic [BPPW-1:0] bpp,
  output logic [SAW-1:0]  word_addr
);
  localparam int BW = SAW + 2;

  logic [LOW-1:0] xbytes;
  logic [BW-1:0]  byte_addr;

  vscreen_pitch #(.DW(DW), .BPPW(BPPW), .OW(LOW)) u_xconv (
    .pixels(xoff),
    .bpp   (bpp),
    .bytes (xbytes)
  );

  always_comb begin
    byte_addr = BW'(pitch) * BW'(yoff) + BW'(xbytes);
    word_addr = byte_addr[BW-1:2];
  end

endmodule

// File: rtl/vscreen_calc.sv
module vscreen_calc #(
  parameter int DW   = 16,
  parameter int BPPW = 6,
  parameter int MW   = 24,
  localparam int LOW = DW + 3,
  localparam int SAW = LOW + DW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   cur_xres,
  input  logic [DW-1:0]   cur_yres,
  input  logic [BPPW-1:0] cur_bpp,
  input  logic [MW-1:0]   vram_bytes,
  output logic [LOW-1:0]  line_offset,
  output logic [DW-1:0]   virt_width,
  output logic [MW-1:0]   virt_height,
  output logic [SAW-1:0]  start_addr,
  output logic            busy,
  output logic            done
);
  import vscreen_pkg::*;

  calc_state_e   state_q;
  logic [DW-1:0] xoff_q, yoff_q, cand_w_q;
  logic [LOW-1:0] cand_p_q;
  logic [LOW-1:0] new_pitch;
  logic [DW-1:0] x_next, y_next;
  logic [SAW-1:0] start_next;
  logic [MW-1:0] quot;
  logic          div_fin;
  logic          accept, width_ok, div_go;
  wr_sel_e       sel;

  assign sel      = wr_sel_e'(wr_sel);
  assign wr_ready = (state_q == ST_IDLE);
  assign busy     = (state_q == ST_DIV);
  assign accept   = wr_valid && wr_ready;

  vscreen_pitch #(.DW(DW), .BPPW(BPPW), .OW(LOW)) u_wconv (
    .pixels(wr_data),
    .bpp   (cur_bpp),
    .bytes (new_pitch)
  );

  assign width_ok = (wr_data >= cur_xres) && (new_pitch != '0);
  assign div_go   = accept && (sel == SEL_WIDTH) && width_ok;

  vscreen_div #(.NW(MW), .DVW(LOW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_go),
    .dividend(vram_bytes),
    .divisor (new_pitch),
    .quotient(quot),
    .fin     (div_fin)
  );

  assign x_next = (accept && sel == SEL_XOFF) ? wr_data : xoff_q;
  assign y_next = (accept && sel == SEL_YOFF) ? wr_data : yoff_q;

  vscreen_start #(.DW(DW), .BPPW(BPPW), .LOW(LOW), .SAW(SAW)) u_start (
    .pitch    (line_offset),
    .xoff     (x_next),
    .yoff     (y_next),
    .bpp      (cur_bpp),
    .word_addr(start_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      xoff_q      <= '0;
      yoff_q      <= '0;
      cand_w_q    <= '0;
      cand_p_q    <= '0;
      line_offset <= '0;
      virt_width  <= '0;
      virt_height <= '0;
      start_addr  <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept) begin
          case (sel)
            SEL_WIDTH: begin
              if (width_ok) begin
                state_q  <= ST_DIV;
                cand_w_q <= wr_data;
                cand_p_q <= new_pitch;
              end else begin
                done <= 1'b1;
              end
            end
            SEL_XOFF, SEL_YOFF: begin
              xoff_q     <= x_next;
              yoff_q     <= y_next;
              start_addr <= start_next;
              done       <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end
      end else if (div_fin) begin
        if (quot >= MW'(cur_yres)) begin
          virt_width  <= cand_w_q;
          virt_height <= quot;
          line_offset <= cand_p_q;
        end
        state_q <= ST_IDLE;
        done    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vscreen_calc_chk.sv
module vscreen_calc_chk #(
  parameter int DW  = 16,
  parameter int MW  = 24,
  parameter int LOW = DW + 3,
  parameter int SAW = LOW + DW - 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic           busy,
  input logic           done,
  input logic [DW-1:0]  cur_xres,
  input logic [DW-1:0]  cur_yres,
  input logic [LOW-1:0] line_offset,
  input logic [DW-1:0]  virt_width,
  input logic [MW-1:0]  virt_height,
  input logic [SAW-1:0] start_addr
);

  // R6
  height_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(virt_height) |-> done);

  // R6
  pitch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_offset) |-> done);

  // R4
  width_covers_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(virt_width) |-> virt_width >= $past(cur_xres));

  // R7
  height_covers_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(virt_width) |-> virt_height >= MW'($past(cur_yres)));

  // R8
  start_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(start_addr) |-> done);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_valid && wr_ready));

endmodule

bind vscreen_calc vscreen_calc_chk #(.DW(DW), .MW(MW), .LOW(LOW), .SAW(SAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .busy       (busy),
  .done       (done),
  .cur_xres   (cur_xres),
  .cur_yres   (cur_yres),
  .line_offset(line_offset),
  .virt_width (virt_width),
  .virt_height(virt_height),
  .start_addr (start_addr)
);

// File: tb/vscreen_calc_tb.sv
module vscreen_calc_tb;
  localparam int DW = 16, BPPW = 6, MW = 24;
  localparam int LOW = DW + 3, SAW = LOW + DW - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0, cur_xres = '0, cur_yres = '0;
  logic [BPPW-1:0] cur_bpp = 6'd8;
  logic [MW-1:0] vram_bytes = 24'h100000;
  logic [LOW-1:0] line_offset;
  logic [DW-1:0] virt_width;
  logic [MW-1:0] virt_height;
  logic [SAW-1:0] start_addr;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  longint m_w = 0, m_h = 0, m_p = 0, m_sa = 0, m_x = 0, m_y = 0;

  always #10 clk = ~clk;

  vscreen_calc #(.DW(DW), .BPPW(BPPW), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .cur_xres(cur_xres), .cur_yres(cur_yres),
    .cur_bpp(cur_bpp), .vram_bytes(vram_bytes), .line_offset(line_offset),
    .virt_width(virt_width), .virt_height(virt_height), .start_addr(start_addr),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint to_bytes(input longint px, input longint bpp);
    if (bpp == 4) return px >> 1;
    return px * ((bpp + 7) / 8);
  endfunction

  task automatic check_outputs(input string req);
    chk({req, " line_offset"}, longint'(line_offset), m_p);
    chk({req, " virt_width"},  longint'(virt_width),  m_w);
    chk({req, " virt_height"}, longint'(virt_height), m_h);
    chk({req, " start_addr"},  longint'(start_addr),  m_sa);
  endtask

  // one transfer, then wait for done; returns cycles seen with busy high
  task automatic do_write(input logic [1:0] s, input logic [DW-1:0] d,
                          input string req, output int bcyc);
    bit seen;
    @(negedge clk);
    wr_sel = s; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    bcyc = 0; seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
      if (busy) begin
        bcyc++;
        if (wr_ready) chk({req, " R9 ready low while busy"}, 1, 0);
      end
    end
    chk({req, " R9 done pulse"}, longint'(seen), 1);
    @(negedge clk);
    chk({req, " R9 done single"}, longint'(done), 0);
  endtask

  task automatic width_case(input string req, input longint w);
    int bc;
    longint p, h;
    bit ok;
    p = to_bytes(w, cur_bpp);
    ok = (w >= cur_xres) && (p != 0);
    h = ok ? (longint'(vram_bytes) / p) : 0;
    do_write(2'd0, DW'(w), req, bc);
    if (ok) chk({req, " R10 busy cycles"}, bc, MW + 1);
    else    chk({req, " R5 no divider run"}, bc, 0);
    if (ok && h >= cur_yres) begin
      m_w = w; m_p = p; m_h = h;
    end
    check_outputs(req);
  endtask

  task automatic offset_case(input string req, input logic [1:0] s, input longint v);
    int bc;
    if (s == 2'd1) m_x = v; else m_y = v;
    m_sa = (m_p * m_y + to_bytes(m_x, cur_bpp)) >> 2;
    do_write(s, DW'(v), req, bc);
    check_outputs(req);
  endtask

  task automatic t_reset;
    chk("R1 ready", longint'(wr_ready), 1);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    check_outputs("R1");
  endtask

  task automatic t_unused;
    int bc;
    do_write(2'd3, 16'h1234, "R11", bc);
    check_outputs("R11 unused select");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    cur_xres = 640; cur_yres = 480; cur_bpp = 8;
    width_case("R3 8bpp width 800", 800);
    cur_bpp = 15;
    width_case("R3 15bpp width 640", 640);
    cur_bpp = 4;
    width_case("R2 4bpp width 1024", 1024);
    cur_bpp = 8;
    width_case("R4 narrow width 632", 632);
    cur_xres = 0; cur_bpp = 0;
    width_case("R5 zero pitch", 64);
    cur_xres = 1024; cur_yres = 256; cur_bpp = 32;
    width_case("R7 height equals yres", 1024);
    cur_yres = 257;
    width_case("R7 height below yres", 1024);

    cur_xres = 640; cur_yres = 480; cur_bpp = 8;
    width_case("R6 8bpp width 800 again", 800);
    offset_case("R8 x first", 2'd1, 3);
    offset_case("R8 y after x", 2'd2, 10);
    cur_bpp = 4;
    offset_case("R8 4bpp x", 2'd1, 21);
    cur_bpp = 32;
    offset_case("R8 32bpp y", 2'd2, 7);
    t_unused();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule